// File: doc/BRIEF.md
# Decode-Stage Stall and Bubble Controller

This block sits at the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). Operands are read from the register file in decode and written back five stages deep, so an instruction in decode may name a register that an older instruction in flight has not yet written. The block compares each decode source register number with the destination held in the execute, memory and write-back pipeline registers. When it finds a conflict it freezes the program counter, holds the fetch/decode register, and turns the decode instruction into a bubble by clearing its register-write and memory-write enables on their way into the decode/execute register.

A mode input selects between two policies. With forwarding off, any live match in the three later stages stalls. With forwarding on, the forwarding paths cover ALU results, so only a load in execute whose destination is needed by decode causes a stall. The decision is purely combinational. The surrounding pipeline registers update on the rising clock edge and load nops on a synchronous reset.

Top module: `hazard_stall_ctrl`

## Requirements
- R1: A decode source equal to register 0 never produces a stall, whatever the later stages hold.
- R2: With `fwd_en` = 0, a stall is raised when a nonzero decode source equals `ex_dst`, `mem_dst` or `wb_dst` and that stage's write enable is 1.
- R3: A destination match in a stage whose write enable is 0 does not produce a stall.
- R4: With `fwd_en` = 1, a stall is raised when `ex_mem_rd` = 1, `ex_wen` = 1 and a nonzero decode source equals `ex_dst`; matches against `mem_dst` or `wb_dst` are ignored.
- R5: With `fwd_en` = 1, a match against `ex_dst` while `ex_mem_rd` = 0 does not stall.
- R6: During a stall `pc_hold`, `ifid_hold` and `bubble` are all 1; without a stall all three are 0. After a reset that loads nops into every pipeline register, none is raised.
- R7: During a stall `idex_reg_we` and `idex_mem_we` are 0; otherwise they equal `dec_reg_we` and `dec_mem_we`.
- R8: Every decode source takes part: source 0 sits in `dec_srcs` bits [ADDR_W-1:0] and source 1 in bits [2*ADDR_W-1:ADDR_W], and a match on either one stalls.
- R9: In a pipeline built around the block, an instruction reading the register written by the instruction directly ahead of it stalls for three cycles with forwarding off, one cycle with forwarding on when the producer is a load, and zero cycles with forwarding on when the producer is not a load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dec_srcs | input | NUM_SRC*ADDR_W | Source register numbers of the decode instruction, source 0 in the low bits |
| dec_reg_we | input | 1 | Register-write enable decoded for the decode instruction |
| dec_mem_we | input | 1 | Memory-write enable decoded for the decode instruction |
| ex_dst | input | ADDR_W | Destination register held in the decode/execute register |
| ex_wen | input | 1 | Register-write enable held in the decode/execute register |
| ex_mem_rd | input | 1 | The instruction in execute reads memory (a load) |
| mem_dst | input | ADDR_W | Destination register held in the execute/memory register |
| mem_wen | input | 1 | Register-write enable held in the execute/memory register |
| wb_dst | input | ADDR_W | Destination register held in the memory/write-back register |
| wb_wen | input | 1 | Register-write enable held in the memory/write-back register |
| fwd_en | input | 1 | 1 = forwarding paths present, 0 = no forwarding |
| pc_hold | output | 1 | Keep the program counter unchanged this cycle |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged this cycle |
| bubble | output | 1 | The decode instruction enters execute as a nop |
| idex_reg_we | output | 1 | Register-write enable to load into the decode/execute register |
| idex_mem_we | output | 1 | Memory-write enable to load into the decode/execute register |

## Verification
The bench builds the block with its defaults, ADDR_W = 5 and NUM_SRC = 2, which gives the usual 32-register file with two operands per instruction. Two sources make it possible to show that a match on the second source stalls while the first names register 0, and five-bit numbers leave room for distinct destinations in all three later stages in one vector. A small pipeline model inside the bench, driven by the block's hold and bubble outputs, brings the three-cycle, one-cycle and zero-cycle stall lengths within reach.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

   // Later pipeline stages whose destinations are compared, in age order.
   typedef enum int unsigned {
      STG_EX  = 0,
      STG_MEM = 1,
      STG_WB  = 2
   } stage_e;

   localparam int unsigned NUM_LATE_STG = 3;

   // Hazard policy selected by the mode input.
   typedef enum logic {
      FWD_OFF = 1'b0,
      FWD_ON  = 1'b1
   } fwd_mode_e;

endpackage

// File: rtl/hzd_dst_cmp.sv
module hzd_dst_cmp #(
   parameter int unsigned ADDR_W = 5
) (
   input  logic [ADDR_W-1:0] src,
   input  logic [ADDR_W-1:0] dst,
   input  logic              wen,
   output logic              hit
);

   logic src_live;

   // Register 0 is hard-wired, so it never waits on a producer.
   assign src_live = |src;
   assign hit      = src_live && wen && (src == dst);

endmodule

// File: rtl/hzd_src_probe.sv
module hzd_src_probe #(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned NSTG   = 3
) (
   input  logic [ADDR_W-1:0]      src,
   input  logic [NSTG*ADDR_W-1:0] dst_flat,
   input  logic [NSTG-1:0]        wen_vec,
   output logic [NSTG-1:0]        hits
);

   for (genvar st = 0; st < NSTG; st++) begin : g_stage
      hzd_dst_cmp #(
         .ADDR_W(ADDR_W)
      ) cmp_i (
         .src (src),
         .dst (dst_flat[st*ADDR_W +: ADDR_W]),
         .wen (wen_vec[st]),
         .hit (hits[st])
      );
   end

endmodule

// File: rtl/hzd_stall_merge.sv
module hzd_stall_merge
   import hzd_pkg::*;
#(
   parameter int unsigned NUM_SRC = 2,
   parameter int unsigned NSTG    = 3
) (
   input  logic [NUM_SRC*NSTG-1:0] hits_flat,
   input  logic                    ex_mem_rd,
   input  fwd_mode_e               mode,
   output logic                    stall
);

   localparam int unsigned EX_COL = int'(STG_EX);

   logic [NUM_SRC-1:0] ex_col;

   // Gather the execute-stage column: one hit bit per source.
   for (genvar s = 0; s < NUM_SRC; s++) begin : g_col
      assign ex_col[s] = hits_flat[s*NSTG + EX_COL];
   end

   always_comb begin
      unique case (mode)
         FWD_ON:  stall = ex_mem_rd && (|ex_col);
         default: stall = |hits_flat;
      endcase
   end

endmodule

// File: rtl/hazard_stall_ctrl.sv
module hazard_stall_ctrl
   import hzd_pkg::*;
#(
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned NUM_SRC = 2
) (
   input  logic [NUM_SRC*ADDR_W-1:0] dec_srcs,
   input  logic                      dec_reg_we,
   input  logic                      dec_mem_we,
   input  logic [ADDR_W-1:0]         ex_dst,
   input  logic                      ex_wen,
   input  logic                      ex_mem_rd,
   input  logic [ADDR_W-1:0]         mem_dst,
   input  logic                      mem_wen,
   input  logic [ADDR_W-1:0]         wb_dst,
   input  logic                      wb_wen,
   input  logic                      fwd_en,
   output logic                      pc_hold,
   output logic                      ifid_hold,
   output logic                      bubble,
   output logic                      idex_reg_we,
   output logic                      idex_mem_we
);

   localparam int unsigned NSTG   = NUM_LATE_STG;
   localparam int unsigned HIT_W  = NUM_SRC * NSTG;

   if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_addr
      $error("hazard_stall_ctrl: ADDR_W must lie in 1..8");
   end
   if (NUM_SRC < 1 || NUM_SRC > 4) begin : g_bad_src
      $error("hazard_stall_ctrl: NUM_SRC must lie in 1..4");
   end

   logic [NSTG*ADDR_W-1:0] dst_flat;
   logic [NSTG-1:0]        wen_vec;
   logic [HIT_W-1:0]       hits_flat;
   logic                   stall;
   fwd_mode_e              mode;

   always_comb begin
      dst_flat = '0;
      dst_flat[int'(STG_EX)*ADDR_W  +: ADDR_W] = ex_dst;
      dst_flat[int'(STG_MEM)*ADDR_W +: ADDR_W] = mem_dst;
      dst_flat[int'(STG_WB)*ADDR_W  +: ADDR_W] = wb_dst;
      wen_vec = '0;
      wen_vec[int'(STG_EX)]  = ex_wen;
      wen_vec[int'(STG_MEM)] = mem_wen;
      wen_vec[int'(STG_WB)]  = wb_wen;
   end

   assign mode = fwd_en ? FWD_ON : FWD_OFF;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      hzd_src_probe #(
         .ADDR_W(ADDR_W),
         .NSTG  (NSTG)
      ) probe_i (
         .src      (dec_srcs[s*ADDR_W +: ADDR_W]),
         .dst_flat (dst_flat),
         .wen_vec  (wen_vec),
         .hits     (hits_flat[s*NSTG +: NSTG])
      );
   end

   hzd_stall_merge #(
      .NUM_SRC(NUM_SRC),
      .NSTG   (NSTG)
   ) merge_i (
      .hits_flat (hits_flat),
      .ex_mem_rd (ex_mem_rd),
      .mode      (mode),
      .stall     (stall)
   );

   // Freeze fetch and the fetch/decode register; turn decode into a nop.
   assign pc_hold     = stall;
   assign ifid_hold   = stall;
   assign bubble      = stall;
   assign idex_reg_we = dec_reg_we && !stall;
   assign idex_mem_we = dec_mem_we && !stall;

endmodule

// File: rtl/hazard_stall_chk.sv
module hazard_stall_chk #(
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned NUM_SRC = 2
) (
   input logic [NUM_SRC*ADDR_W-1:0] dec_srcs,
   input logic                      dec_reg_we,
   input logic                      dec_mem_we,
   input logic [ADDR_W-1:0]         ex_dst,
   input logic                      ex_wen,
   input logic                      ex_mem_rd,
   input logic [ADDR_W-1:0]         mem_dst,
   input logic                      mem_wen,
   input logic [ADDR_W-1:0]         wb_dst,
   input logic                      wb_wen,
   input logic                      fwd_en,
   input logic                      pc_hold,
   input logic                      ifid_hold,
   input logic                      bubble,
   input logic                      idex_reg_we,
   input logic                      idex_mem_we
);

   logic known;

   assign known = !$isunknown({dec_srcs, dec_reg_we, dec_mem_we, ex_dst, ex_wen,
                               ex_mem_rd, mem_dst, mem_wen, wb_dst, wb_wen, fwd_en,
                               pc_hold, ifid_hold, bubble, idex_reg_we, idex_mem_we});

   always_comb begin
      if (known) begin
         assert_zero_srcs_quiet_R1: assert (!(dec_srcs == '0) || !pc_hold)
            else $error("zero sources raised a stall");
         assert_ex_alu_match_stalls_R2: assert (!(!fwd_en && ex_wen && ex_dst != '0
                                                  && dec_srcs[ADDR_W-1:0] == ex_dst) || bubble)
            else $error("execute match without forwarding did not stall");
         assert_no_writers_no_stall_R3: assert (ex_wen || mem_wen || wb_wen || !bubble)
            else $error("stall with no stage writing");
         assert_fwd_needs_load_R5: assert (!(fwd_en && !ex_mem_rd) || !bubble)
            else $error("forwarding mode stalled without a load in execute");
         assert_holds_agree_R6: assert (pc_hold == ifid_hold && ifid_hold == bubble)
            else $error("hold and bubble outputs disagree");
         assert_bubble_kills_we_R7: assert (!bubble || (!idex_reg_we && !idex_mem_we))
            else $error("bubble left a write enable set");
         assert_pass_we_R7: assert (bubble || (idex_reg_we == dec_reg_we
                                               && idex_mem_we == dec_mem_we))
            else $error("write enables altered without a stall");
      end
   end

endmodule

bind hazard_stall_ctrl hazard_stall_chk #(
   .ADDR_W (ADDR_W),
   .NUM_SRC(NUM_SRC)
) chk_i (.*);

// File: tb/hazard_stall_ctrl_tb_top.sv
`timescale 1ns/1ps
module hazard_stall_ctrl_tb_top;

   localparam int unsigned AW = 5;
   localparam int unsigned NS = 2;
   localparam int NVEC = 14;

   typedef struct packed {
      logic [3:0]    req;
      logic          fwd;
      logic [AW-1:0] sa;
      logic [AW-1:0] sb;
      logic [AW-1:0] exd;
      logic          exw;
      logic          exr;
      logic [AW-1:0] md;
      logic          mw;
      logic [AW-1:0] wd;
      logic          ww;
      logic          exp;
   } vec_t;

   // req fwd  sa     sb     exd   exw  exr   md     mw    wd     ww    stall
   localparam vec_t VECS [NVEC] = '{
      '{4'd1, 1'b0, 5'd0, 5'd0, 5'd0, 1'b1, 1'b0, 5'd0, 1'b1, 5'd0, 1'b1, 1'b0}, // R1
      '{4'd2, 1'b0, 5'd3, 5'd0, 5'd3, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1}, // R2 ex
      '{4'd2, 1'b0, 5'd4, 5'd0, 5'd1, 1'b1, 1'b0, 5'd4, 1'b1, 5'd0, 1'b0, 1'b1}, // R2 mem
      '{4'd2, 1'b0, 5'd5, 5'd0, 5'd1, 1'b1, 1'b0, 5'd2, 1'b1, 5'd5, 1'b1, 1'b1}, // R2 wb
      '{4'd8, 1'b0, 5'd1, 5'd7, 5'd2, 1'b1, 1'b0, 5'd7, 1'b1, 5'd3, 1'b1, 1'b1}, // R8
      '{4'd3, 1'b0, 5'd3, 5'd3, 5'd3, 1'b0, 1'b0, 5'd3, 1'b0, 5'd3, 1'b0, 1'b0}, // R3
      '{4'd2, 1'b0, 5'd3, 5'd4, 5'd5, 1'b1, 1'b0, 5'd6, 1'b1, 5'd7, 1'b1, 1'b0}, // R2 none
      '{4'd4, 1'b1, 5'd9, 5'd0, 5'd9, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1}, // R4 load a
      '{4'd4, 1'b1, 5'd1, 5'd9, 5'd9, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1}, // R4 load b
      '{4'd5, 1'b1, 5'd9, 5'd0, 5'd9, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0}, // R5
      '{4'd4, 1'b1, 5'd9, 5'd0, 5'd2, 1'b1, 1'b1, 5'd9, 1'b1, 5'd9, 1'b1, 1'b0}, // R4 late
      '{4'd1, 1'b1, 5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0}, // R1 fwd
      '{4'd3, 1'b1, 5'd9, 5'd0, 5'd9, 1'b0, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0}, // R3 fwd
      '{4'd8, 1'b0, 5'd0, 5'd6, 5'd0, 1'b1, 1'b0, 5'd6, 1'b1, 5'd0, 1'b0, 1'b1}  // R8 b
   };

   typedef struct packed {
      logic [AW-1:0] sa;
      logic [AW-1:0] sb;
      logic [AW-1:0] dst;
      logic          wen;
      logic          rd;
   } ins_t;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   // DUT connections
   logic [NS*AW-1:0] dec_srcs;
   logic dec_reg_we, dec_mem_we, ex_wen, ex_mem_rd, mem_wen, wb_wen, fwd_en;
   logic [AW-1:0] ex_dst, mem_dst, wb_dst;
   logic pc_hold, ifid_hold, bubble, idex_reg_we, idex_mem_we;

   // table-mode drivers
   logic [NS*AW-1:0] t_srcs = '0;
   logic t_rwe = 1'b0, t_mwe = 1'b0, t_exw = 1'b0, t_exr = 1'b0, t_mw = 1'b0, t_ww = 1'b0;
   logic t_fwd = 1'b0;
   logic [AW-1:0] t_exd = '0, t_md = '0, t_wd = '0;

   // pipeline-model state
   logic use_pipe = 1'b0;
   logic pipe_rst = 1'b1;
   logic prog_load = 1'b0;
   logic pipe_fwd = 1'b0;
   int   pc;
   int   bub_cnt;
   ins_t ifid, idex, exmem, memwb;

   int n_checks = 0;
   int n_fail   = 0;

   always_comb begin
      if (use_pipe) begin
         dec_srcs   = {ifid.sb, ifid.sa};
         dec_reg_we = ifid.wen;
         dec_mem_we = 1'b0;
         ex_dst     = idex.dst;
         ex_wen     = idex.wen;
         ex_mem_rd  = idex.rd;
         mem_dst    = exmem.dst;
         mem_wen    = exmem.wen;
         wb_dst     = memwb.dst;
         wb_wen     = memwb.wen;
         fwd_en     = pipe_fwd;
      end else begin
         dec_srcs   = t_srcs;
         dec_reg_we = t_rwe;
         dec_mem_we = t_mwe;
         ex_dst     = t_exd;
         ex_wen     = t_exw;
         ex_mem_rd  = t_exr;
         mem_dst    = t_md;
         mem_wen    = t_mw;
         wb_dst     = t_wd;
         wb_wen     = t_ww;
         fwd_en     = t_fwd;
      end
   end

   hazard_stall_ctrl #(
      .ADDR_W (AW),
      .NUM_SRC(NS)
   ) dut_i (
      .dec_srcs    (dec_srcs),
      .dec_reg_we  (dec_reg_we),
      .dec_mem_we  (dec_mem_we),
      .ex_dst      (ex_dst),
      .ex_wen      (ex_wen),
      .ex_mem_rd   (ex_mem_rd),
      .mem_dst     (mem_dst),
      .mem_wen     (mem_wen),
      .wb_dst      (wb_dst),
      .wb_wen      (wb_wen),
      .fwd_en      (fwd_en),
      .pc_hold     (pc_hold),
      .ifid_hold   (ifid_hold),
      .bubble      (bubble),
      .idex_reg_we (idex_reg_we),
      .idex_mem_we (idex_mem_we)
   );

   // Program: producer writes r3, consumer reads r3, then nops.
   function automatic ins_t fetch(int idx);
      ins_t i;
      i = '0;
      if (idx == 0) i = '{sa: 5'd0, sb: 5'd0, dst: 5'd3, wen: 1'b1, rd: prog_load};
      else if (idx == 1) i = '{sa: 5'd3, sb: 5'd0, dst: 5'd5, wen: 1'b1, rd: 1'b0};
      return i;
   endfunction

   // Pipeline registers around the block: rising edge, synchronous reset to nops.
   always_ff @(posedge clk) begin
      if (pipe_rst) begin
         pc      <= 0;
         bub_cnt <= 0;
         ifid    <= '0;
         idex    <= '0;
         exmem   <= '0;
         memwb   <= '0;
      end else begin
         if (!pc_hold) pc <= pc + 1;
         if (!ifid_hold) ifid <= fetch(pc);
         idex     <= '{sa: ifid.sa, sb: ifid.sb, dst: ifid.dst,
                       wen: idex_reg_we, rd: ifid.rd && !bubble};
         exmem    <= idex;
         memwb    <= exmem;
         if (bubble) bub_cnt <= bub_cnt + 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run_pipe(input logic load, input logic fwd, input int exp, input string tag);
      @(negedge clk);
      use_pipe  = 1'b1;
      pipe_rst  = 1'b1;
      prog_load = load;
      pipe_fwd  = fwd;
      repeat (2) @(posedge clk);
      @(negedge clk);
      pipe_rst = 1'b0;
      repeat (12) @(posedge clk);
      @(negedge clk);
      chk(tag, bub_cnt, exp);
   endtask

   initial begin : watchdog
      #200000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      // Reset state: every pipeline register holds a nop (R6).
      use_pipe = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R6 reset pc_hold", pc_hold, 0);
      chk("R6 reset bubble", bubble, 0);
      use_pipe = 1'b0;

      // Vector table: R1 R2 R3 R4 R5 R8 and hold/enable outputs (R6, R7).
      for (int v = 0; v < NVEC; v++) begin
         @(negedge clk);
         t_srcs = {VECS[v].sb, VECS[v].sa};
         t_fwd  = VECS[v].fwd;
         t_exd  = VECS[v].exd;  t_exw = VECS[v].exw;  t_exr = VECS[v].exr;
         t_md   = VECS[v].md;   t_mw  = VECS[v].mw;
         t_wd   = VECS[v].wd;   t_ww  = VECS[v].ww;
         t_rwe  = 1'b1;         t_mwe = 1'b1;
         #1;
         chk($sformatf("R%0d vec %0d pc_hold", VECS[v].req, v), pc_hold, VECS[v].exp);
         chk($sformatf("R6 vec %0d ifid_hold", v), ifid_hold, VECS[v].exp);
         chk($sformatf("R6 vec %0d bubble", v), bubble, VECS[v].exp);
         chk($sformatf("R7 vec %0d idex_reg_we", v), idex_reg_we, !VECS[v].exp);
         chk($sformatf("R7 vec %0d idex_mem_we", v), idex_mem_we, !VECS[v].exp);
      end

      // R7: enables pass unchanged when no stall, in both polarities.
      @(negedge clk);
      t_srcs = '0; t_exw = 1'b0; t_mw = 1'b0; t_ww = 1'b0; t_fwd = 1'b0;
      t_rwe = 1'b0; t_mwe = 1'b1;
      #1;
      chk("R7 pass reg_we low", idex_reg_we, 0);
      chk("R7 pass mem_we high", idex_mem_we, 1);

      // R9: stall lengths for a dependent instruction directly behind its producer.
      run_pipe(1'b0, 1'b0, 3, "R9 no forwarding alu producer");
      run_pipe(1'b1, 1'b0, 3, "R9 no forwarding load producer");
      run_pipe(1'b1, 1'b1, 1, "R9 forwarding load producer");
      run_pipe(1'b0, 1'b1, 0, "R9 forwarding alu producer");

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule